// File: doc/BRIEF.md
# Digital I/O Register Bus Interface

This block is the register front end of a 32-channel digital port in which every pin is shared by an input buffer and an open-drain low-side switch. A 16-bit bus master reads two words of sampled pin levels. It reads and writes two words of output latches, and each latch bit drives one switch gate. The master also reaches five 8-bit interrupt configuration registers that live in a separate interrupt controller. For those registers the block only forwards the index, the write strobe and the low data byte, and it returns the controller's read byte.

Because the input and output of a channel share one pin, software can check an output in two ways. Reading the output word returns the value held in the gate latch. Reading the input word returns the real drain level, which for a loaded channel is the bitwise inverse of the gate value. Pin levels pass through a two-stage synchronizer before any read can see them. Every access is taken when `sel` is sampled high at a clock edge, and it is answered with a one-cycle acknowledge in the next cycle. Both the asynchronous power-on reset and the synchronous system reset open all switches.

Top module: `dio_regif`

## Requirements
- R1: While `rst_n` is low, and immediately after it falls at any time, `gate_out` is all zeros (every switch open) and `ack` is low.
- R2: Word address 0 returns channels 0..15 and word address 1 returns channels 16..31, with the lowest-numbered channel in bit 0. The value returned is the pin level as sampled through two clock edges.
- R3: A write to word address 2 loads `gate_out[15:0]` and a write to word address 3 loads `gate_out[31:16]`, using the same channel-to-bit order. A 1 turns the switch on and a 0 turns it off. The new value appears after the capturing edge.
- R4: Reading word address 2 or 3 returns the current gate latch contents.
- R5: With each pin loaded as the inverse of its gate, and with no other load pulling it low, an input word reads back as the bitwise inverse of the matching output word.
- R6: `be[0]` enables write lane bits 7:0 and `be[1]` enables bits 15:8. A lane whose enable is low keeps its old contents.
- R7: A cycle with `sys_rst` high clears every gate latch at that edge, and this takes priority over a write in the same cycle.
- R8: Word addresses 4..8 map to interrupt registers 0..4. On a write with `be[0]` set, `irq_idx` equals the address minus 4, `irq_wr_stb` is high and `irq_wdata` carries bits 7:0. A write with `be[0]` clear produces no strobe. A read returns bits 15:8 as all ones, with `irq_rdata` in bits 7:0.
- R9: An access to a word address of 9 or above gets no acknowledge and changes no latch.
- R10: For every in-map access, `ack` is high for exactly the one cycle after the edge that sampled `sel`, and read data is valid on `rdata` while `ack` is high.
- R11: The input words are read-only. A write to word address 0 or 1 is acknowledged but leaves `gate_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Synchronous system reset, active high |
| sel | input | 1 | Access request, sampled at each clock edge |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Word address |
| be | input | 2 | Byte-lane write enables |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid with ack |
| ack | output | 1 | One-cycle access acknowledge |
| pins_in | input | 32 | Raw pin levels from the input buffers |
| gate_out | output | 32 | Switch gate drives, 1 = on |
| irq_idx | output | 3 | Interrupt register index |
| irq_wr_stb | output | 1 | Interrupt register write strobe |
| irq_wdata | output | 8 | Interrupt register write byte |
| irq_rdata | input | 8 | Interrupt register read byte |

## Verification
The hardest case to reach is the loopback read. The value returned from an input word depends on a gate written earlier, then reflected through the external pin load, and then carried through the synchronizer. The bench closes this loop with a pin model equal to the inverted gates ANDed with a per-channel external level. It writes the output words, waits past the synchronizer depth, and then expects the inverted pattern from the input words. It also pulls the external levels low and expects the raw pattern with the switches off. Out-of-map accesses are verified by a scoreboard: any acknowledge that arrives with no expected item queued counts as a miscompare.

// File: rtl/dio_regif_pkg.sv
package dio_regif_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      SPC_IN   = 2'd0,
      SPC_OUT  = 2'd1,
      SPC_IRQ  = 2'd2,
      SPC_NONE = 2'd3
   } space_e;
endpackage

// File: rtl/dio_regif_sync.sv
module dio_regif_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dio_regif_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dio_regif_dec.sv
module dio_regif_dec
   import dio_regif_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int WORDS    = 2,
   parameter int IRQ_REGS = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output space_e            space,
   output logic [ADDR_W-1:0] idx
);
   localparam int MAP_END = 2*WORDS + IRQ_REGS;

   if (MAP_END >= (1 << ADDR_W)) begin : g_bad_map
      $error("dio_regif_dec: register map does not fit ADDR_W");
   end

   localparam logic [ADDR_W-1:0] OUT_BASE = ADDR_W'(WORDS);
   localparam logic [ADDR_W-1:0] IRQ_BASE = ADDR_W'(2*WORDS);
   localparam logic [ADDR_W-1:0] END_ADDR = ADDR_W'(MAP_END);

   always_comb begin
      if (addr < OUT_BASE) begin
         space = SPC_IN;
         idx   = addr;
      end else if (addr < IRQ_BASE) begin
         space = SPC_OUT;
         idx   = addr - OUT_BASE;
      end else if (addr < END_ADDR) begin
         space = SPC_IRQ;
         idx   = addr - IRQ_BASE;
      end else begin
         space = SPC_NONE;
         idx   = '0;
      end
   end
endmodule

// File: rtl/dio_regif_outlat.sv
module dio_regif_outlat
   import dio_regif_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int WORDS  = 2,
   parameter int IDX_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sys_rst,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        word_idx,
   input  logic [DATA_W/BYTE_W-1:0] be,
   input  logic [DATA_W-1:0]       wdata,
   output logic [DATA_W*WORDS-1:0] gates
);
   localparam int LANES = DATA_W / BYTE_W;

   if (DATA_W % BYTE_W != 0) begin : g_bad_width
      $error("dio_regif_outlat: DATA_W must be a whole number of bytes");
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [BYTE_W-1:0] lane_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)
               lane_q <= '0;
            else if (sys_rst)
               lane_q <= '0;
            else if (wr_en && word_idx == IDX_W'(w) && be[l])
               lane_q <= wdata[l*BYTE_W +: BYTE_W];
         assign gates[w*DATA_W + l*BYTE_W +: BYTE_W] = lane_q;
      end
   end
endmodule

// File: rtl/dio_regif.sv
module dio_regif
   import dio_regif_pkg::*;
#(
   parameter int NUM_CH      = 32,
   parameter int DATA_W      = 16,
   parameter int IRQ_W       = 8,
   parameter int IRQ_REGS    = 5,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   localparam int LANES      = DATA_W / BYTE_W,
   localparam int IRQ_IDX_W  = (IRQ_REGS > 1) ? $clog2(IRQ_REGS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sys_rst,
   input  logic                 sel,
   input  logic                 we,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [LANES-1:0]     be,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   output logic                 ack,
   input  logic [NUM_CH-1:0]    pins_in,
   output logic [NUM_CH-1:0]    gate_out,
   output logic [IRQ_IDX_W-1:0] irq_idx,
   output logic                 irq_wr_stb,
   output logic [IRQ_W-1:0]     irq_wdata,
   input  logic [IRQ_W-1:0]     irq_rdata
);
   localparam int WORDS = NUM_CH / DATA_W;

   if (NUM_CH % DATA_W != 0) begin : g_bad_ch
      $error("dio_regif: NUM_CH must be a multiple of DATA_W");
   end
   if (IRQ_W > DATA_W || IRQ_W < 1 || IRQ_W > BYTE_W) begin : g_bad_irq
      $error("dio_regif: IRQ_W must fit the low byte lane");
   end

   space_e            space;
   logic [ADDR_W-1:0] idx;
   logic [NUM_CH-1:0] pins_sync;
   logic [DATA_W-1:0] rd_next;
   logic [DATA_W-1:0] rdata_q;
   logic              ack_q;

   dio_regif_dec #(.ADDR_W(ADDR_W), .WORDS(WORDS), .IRQ_REGS(IRQ_REGS)) u_dec (
      .addr  (addr),
      .space (space),
      .idx   (idx)
   );

   dio_regif_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_in),
      .q     (pins_sync)
   );

   dio_regif_outlat #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(ADDR_W)) u_outlat (
      .clk      (clk),
      .rst_n    (rst_n),
      .sys_rst  (sys_rst),
      .wr_en    (sel && we && space == SPC_OUT),
      .word_idx (idx),
      .be       (be),
      .wdata    (wdata),
      .gates    (gate_out)
   );

   // Interrupt controller side: index and strobe pass straight through
   assign irq_idx    = idx[IRQ_IDX_W-1:0];
   assign irq_wr_stb = sel && we && be[0] && space == SPC_IRQ;
   assign irq_wdata  = wdata[IRQ_W-1:0];

   always_comb begin
      rd_next = '1;
      unique case (space)
         SPC_IN: begin
            for (int w = 0; w < WORDS; w++)
               if (idx == ADDR_W'(w)) rd_next = pins_sync[w*DATA_W +: DATA_W];
         end
         SPC_OUT: begin
            for (int w = 0; w < WORDS; w++)
               if (idx == ADDR_W'(w)) rd_next = gate_out[w*DATA_W +: DATA_W];
         end
         SPC_IRQ:  rd_next = {{(DATA_W-IRQ_W){1'b1}}, irq_rdata};
         default:  rd_next = '1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ack_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q <= sel && space != SPC_NONE;
         if (sel && !we) rdata_q <= rd_next;
      end

   assign ack   = ack_q;
   assign rdata = rdata_q;
endmodule

// File: rtl/dio_regif_chk.sv
module dio_regif_chk #(
   parameter int NUM_CH    = 32,
   parameter int DATA_W    = 16,
   parameter int IRQ_REGS  = 5,
   parameter int ADDR_W    = 4,
   parameter int LANES     = 2,
   parameter int IRQ_IDX_W = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sys_rst,
   input logic                 sel,
   input logic                 we,
   input logic [ADDR_W-1:0]    addr,
   input logic [LANES-1:0]     be,
   input logic [DATA_W-1:0]    wdata,
   input logic                 ack,
   input logic [NUM_CH-1:0]    gate_out,
   input logic [IRQ_IDX_W-1:0] irq_idx,
   input logic                 irq_wr_stb
);
   localparam int WORDS = NUM_CH / DATA_W;
   localparam logic [ADDR_W-1:0] OUT0 = ADDR_W'(WORDS);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(2*WORDS + IRQ_REGS);

   // R10
   ack_after_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(sel));

   // R9
   no_ack_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && addr >= LAST) |=> !ack);

   // R7
   sysrst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |=> gate_out == '0);

   // R3
   out_word0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && we && addr == OUT0 && be == '1 && !sys_rst)
      |=> gate_out[DATA_W-1:0] == $past(wdata));

   // R11
   input_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && we && addr < OUT0 && !sys_rst) |=> $stable(gate_out));

   // R8
   irq_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_wr_stb |-> (int'(irq_idx) < IRQ_REGS && be[0]));
endmodule

bind dio_regif dio_regif_chk #(
   .NUM_CH(NUM_CH), .DATA_W(DATA_W), .IRQ_REGS(IRQ_REGS),
   .ADDR_W(ADDR_W), .LANES(LANES), .IRQ_IDX_W(IRQ_IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .sel(sel), .we(we),
   .addr(addr), .be(be), .wdata(wdata), .ack(ack), .gate_out(gate_out),
   .irq_idx(irq_idx), .irq_wr_stb(irq_wr_stb)
);

// File: tb/tb_dio_regif.sv
`timescale 1ns/1ps
module tb_dio_regif;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sys_rst = 1'b0;
   logic        sel = 1'b0;
   logic        we = 1'b0;
   logic [3:0]  addr = '0;
   logic [1:0]  be = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        ack;
   logic [31:0] pins_in;
   logic [31:0] gate_out;
   logic [2:0]  irq_idx;
   logic        irq_wr_stb;
   logic [7:0]  irq_wdata;
   logic [7:0]  irq_rdata;
   logic [31:0] ext_lvl = '1;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   typedef struct {
      logic [15:0] exp;
      bit          chk_data;
      string       req;
   } item_t;
   item_t sb[$];

   always #4 clk = ~clk;

   // Loaded pin: pulled up unless the switch is on or the outside pulls it low
   assign pins_in = ~gate_out & ext_lvl;

   // Interrupt controller model
   logic [7:0] irq_mem [5];
   initial for (int i = 0; i < 5; i++) irq_mem[i] = 8'h00;
   always @(posedge clk) if (irq_wr_stb && irq_idx < 3'd5) irq_mem[irq_idx] <= irq_wdata;
   assign irq_rdata = (irq_idx < 3'd5) ? irq_mem[irq_idx] : 8'h00;

   dio_regif dut (
      .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .sel(sel), .we(we),
      .addr(addr), .be(be), .wdata(wdata), .rdata(rdata), .ack(ack),
      .pins_in(pins_in), .gate_out(gate_out), .irq_idx(irq_idx),
      .irq_wr_stb(irq_wr_stb), .irq_wdata(irq_wdata), .irq_rdata(irq_rdata)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Monitor: pops one expected item per acknowledge
   always @(negedge clk) begin
      if (rst_n && ack) begin
         if (sb.size() == 0) begin
            check(1'b0, "R9 unexpected ack", 32'(ack), 32'd0);
         end else begin
            item_t it;
            it = sb.pop_front();
            if (it.chk_data) check(rdata === it.exp, it.req, 32'(rdata), 32'(it.exp));
         end
      end
   end

   // Driver: one access, returns at the negedge where ack is visible
   task automatic access(input logic [3:0] a, input bit w, input logic [1:0] b,
                         input logic [15:0] d, input bit mapped,
                         input logic [15:0] exp, input string req);
      @(negedge clk);
      if (mapped) begin
         item_t it;
         it.exp = exp; it.chk_data = !w; it.req = req;
         sb.push_back(it);
      end
      sel = 1'b1; we = w; addr = a; be = b; wdata = d;
      @(negedge clk);
      sel = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string req);
      access(a, 1'b0, 2'b00, 16'h0, 1'b1, exp, req);
   endtask

   task automatic wr(input logic [3:0] a, input logic [1:0] b, input logic [15:0] d);
      access(a, 1'b1, b, d, 1'b1, 16'h0, "write");
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog R10: actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(gate_out === 32'h0, "R1 gate during reset", gate_out, 32'h0);
      check(ack === 1'b0, "R1 ack during reset", 32'(ack), 32'h0);
      rst_n = 1'b1;
      settle();

      // R4 reset readback
      rd(4'd2, 16'h0000, "R4 out A after reset");
      rd(4'd3, 16'h0000, "R4 out B after reset");

      // R5 switches off, pulled up
      rd(4'd0, 16'hFFFF, "R5 in A all off");
      // R2 external pattern
      ext_lvl = 32'h1234_A5C3;
      settle();
      rd(4'd0, 16'hA5C3, "R2 in A pattern");
      rd(4'd1, 16'h1234, "R2 in B pattern");
      ext_lvl = '1;

      // R3 output words
      wr(4'd2, 2'b11, 16'h00F0);
      check(gate_out[15:0] === 16'h00F0, "R3 gate A", 32'(gate_out[15:0]), 32'h00F0);
      wr(4'd3, 2'b11, 16'h8001);
      check(gate_out[31:16] === 16'h8001, "R3 gate B", 32'(gate_out[31:16]), 32'h8001);
      rd(4'd2, 16'h00F0, "R4 out A readback");
      rd(4'd3, 16'h8001, "R4 out B readback");

      // R10 ack is one cycle
      check(ack === 1'b1, "R10 ack high", 32'(ack), 32'h1);
      @(negedge clk);
      check(ack === 1'b0, "R10 ack single", 32'(ack), 32'h0);

      // R5 loopback
      settle();
      rd(4'd0, 16'hFF0F, "R5 loopback A");
      rd(4'd1, 16'h7FFE, "R5 loopback B");

      // R6 byte lanes
      wr(4'd2, 2'b01, 16'hABCD);
      check(gate_out[15:0] === 16'h00CD, "R6 low lane", 32'(gate_out[15:0]), 32'h00CD);
      wr(4'd2, 2'b10, 16'h12FF);
      check(gate_out[15:0] === 16'h12CD, "R6 high lane", 32'(gate_out[15:0]), 32'h12CD);
      rd(4'd2, 16'h12CD, "R6 lane readback");

      // R11 input words read-only
      wr(4'd0, 2'b11, 16'hFFFF);
      wr(4'd1, 2'b11, 16'h0000);
      check(gate_out === 32'h8001_12CD, "R11 gates unchanged", gate_out, 32'h8001_12CD);

      // R8 interrupt registers
      wr(4'd4, 2'b01, 16'h003C);
      wr(4'd8, 2'b11, 16'h995A);
      wr(4'd5, 2'b10, 16'h7700);
      rd(4'd4, 16'hFF3C, "R8 irq reg 0");
      rd(4'd8, 16'hFF5A, "R8 irq reg 4");
      rd(4'd5, 16'hFF00, "R8 irq high-lane write ignored");

      // R9 out of map
      access(4'd9, 1'b1, 2'b11, 16'h0000, 1'b0, 16'h0, "");
      access(4'd15, 1'b0, 2'b00, 16'h0, 1'b0, 16'h0, "");
      access(4'd12, 1'b1, 2'b11, 16'hFFFF, 1'b0, 16'h0, "");
      @(negedge clk);
      check(gate_out === 32'h8001_12CD, "R9 no latch change", gate_out, 32'h8001_12CD);
      check(sb.size() == 0, "R9 queue drained", 32'(sb.size()), 32'h0);

      // R7 system reset beats a write
      @(negedge clk);
      sys_rst = 1'b1; sel = 1'b1; we = 1'b1; addr = 4'd3; be = 2'b11; wdata = 16'h5555;
      begin
         item_t it;
         it.exp = '0; it.chk_data = 1'b0; it.req = "write";
         sb.push_back(it);
      end
      @(negedge clk);
      sys_rst = 1'b0; sel = 1'b0; we = 1'b0;
      check(gate_out === 32'h0, "R7 sys reset clears", gate_out, 32'h0);
      rd(4'd3, 16'h0000, "R7 out B after sys reset");

      // R1 asynchronous reset mid-run
      wr(4'd2, 2'b11, 16'hFFFF);
      #1 rst_n = 1'b0;
      #1 check(gate_out === 32'h0, "R1 async clear", gate_out, 32'h0);
      sb.delete();
      @(negedge clk);
      rst_n = 1'b1;
      settle();
      check(sb.size() == 0, "R10 scoreboard empty", 32'(sb.size()), 32'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule